// File: doc/BRIEF.md
# Receive Descriptor DMA Sequencer

This block empties a receive byte FIFO into host memory buffers. Each buffer is described by a three-word descriptor in host memory: word 0 is the link to the next descriptor, word 1 is control and status, and word 2 is the buffer address. The descriptors form a linked list. Software loads the address of the first descriptor, clears the ownership bit in each descriptor it offers, and pulses the receive-enable command. The sequencer then reads a descriptor, waits until the FIFO holds enough data, and copies 32-bit words into the buffer. When the buffer is full, or when the packet ends, it writes a status word back into the descriptor and moves to the next descriptor in the list. One packet can therefore span several buffers.

Data moves in bursts. A burst starts only when the FIFO holds at least the programmed threshold (counted in 8-byte units), or when the FIFO holds the tail of a whole packet. A burst stops when no full word is left in the FIFO, when the packet ends, or when `MAX_BURST` words have been moved. Every memory access is a single-word request held until it is acknowledged. When the sequencer reaches a null link, it stops on the current descriptor and remembers that this descriptor has been used. The next enable then re-reads the link of that descriptor before it goes on.

Top module: `rxd_dma_seq`

## Requirements
- R1: After reset the sequencer is idle: `rx_active`=0, `mem_req`=0, `fifo_rd`=0 and `desc_ptr`=0.
- R2: A `rx_en` pulse while idle, with no used descriptor pending, reads the three words at `desc_ptr`, `desc_ptr`+4 and `desc_ptr`+8, in that order. The order is link, then control/status, then buffer address.
- R3: If bit 31 (owner) of the control word is 1 when it is read, no data moves. The sequencer returns to idle and `desc_ptr` keeps its value.
- R4: With the owner bit clear, no FIFO word is popped until `fifo_level` ≥ 8×`drain_th`, or until `fifo_pkt_whole` is 1.
- R5: Packet words are written in FIFO order to consecutive word addresses, starting at the buffer address.
- R6: When a buffer whose size is in control bits 11:0 (a nonzero multiple of 4) fills while the packet continues, the status is written with bit 30 (more) set and count = size. The rest of the packet goes to the descriptor at the link.
- R7: The descriptor holding the end of a packet receives status at descriptor+4. The status has bit 31 set, bit 30 clear, bit 27 (good) set, and bits 11:0 equal to the bytes placed in that buffer, including a partial last word of 1–3 bytes.
- R8: For a packet whose last word carries `fifo_ovr`, the final status has bit 25 (overrun) set and bit 26 (abort) equal to it, with bit 27 clear.
- R9: After a descriptor whose link is 0, the sequencer goes idle and `desc_ptr` stays on it. The next `rx_en` first re-reads the link at `desc_ptr`, then continues with the descriptor the link names.
- R10: A `ptr_load` while idle sets `desc_ptr` to `ptr_value` and cancels the pending re-read. The next `rx_en` then reads at `ptr_value` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive-enable command pulse |
| ptr_load | input | 1 | Load descriptor pointer (honoured while idle) |
| ptr_value | input | ADDR_W | New descriptor pointer |
| drain_th | input | TH_W | Drain threshold in 8-byte units |
| fifo_level | input | LVL_W | Bytes held in the receive FIFO |
| fifo_pkt_whole | input | 1 | The FIFO holds the last word of a packet |
| fifo_rdata | input | 32 | Head word of the FIFO |
| fifo_last | input | 1 | Head word is the last of its packet |
| fifo_last_bytes | input | 3 | Valid bytes (1–4) in a last word |
| fifo_ovr | input | 1 | Head last word belongs to an overrun packet |
| fifo_rd | output | 1 | Pop the head word |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Request completes this cycle |
| desc_ptr | output | ADDR_W | Current descriptor address |
| rx_active | output | 1 | Sequencer is not idle |

## Verification
The hardest situation to reach from the ports is a stall partway through a packet. The FIFO must sit below the threshold with no packet tail in it, while the descriptor is already loaded. The bench gets there by pushing the packet's words in stages: first fewer bytes than the threshold, with no last word, then enough to cross it, then the tail. Between stages it watches that nothing is popped or written. The re-read path after a null link is reached by letting a packet finish on a descriptor whose link is 0. The bench then patches that link in memory and issues another enable.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CNT_W    = 12;
    localparam int unsigned OWN_BIT  = 31;
    localparam int unsigned MORE_BIT = 30;
    localparam int unsigned GOOD_BIT = 27;
    localparam int unsigned ABRT_BIT = 26;
    localparam int unsigned OVR_BIT  = 25;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REFRESH,
        S_DREAD,
        S_BLOCK,
        S_FRAG,
        S_DWRITE,
        S_ADV
    } rxd_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] buf_addr;
    } rxd_desc_t;

    typedef struct packed {
        logic             more;
        logic             ovr;
        logic [CNT_W-1:0] count;
    } rxd_stat_t;

    function automatic logic [WORD_W-1:0] pack_status(input rxd_stat_t s);
        logic [WORD_W-1:0] w;
        w               = '0;
        w[OWN_BIT]      = 1'b1;
        w[MORE_BIT]     = s.more;
        w[GOOD_BIT]     = !s.more && !s.ovr;
        w[ABRT_BIT]     = s.ovr;
        w[OVR_BIT]      = s.ovr;
        w[CNT_W-1:0]    = s.count;
        return w;
    endfunction

endpackage

// File: rtl/rxd_drain_gate.sv
module rxd_drain_gate #(
    parameter int unsigned LVL_W = 12,
    parameter int unsigned TH_W  = 5
) (
    input  logic [LVL_W-1:0] level,
    input  logic             pkt_whole,
    input  logic [TH_W-1:0]  th,
    output logic             ready,
    output logic             word_avail
);
    localparam int unsigned THB_W = TH_W + 3;
    localparam int unsigned CMP_W = (LVL_W > THB_W) ? LVL_W : THB_W;

    logic [CMP_W-1:0] lvl_x;
    logic [CMP_W-1:0] thr_x;

    always_comb begin
        lvl_x      = CMP_W'(level);
        thr_x      = CMP_W'({th, 3'b000});
        word_avail = (lvl_x >= CMP_W'(4)) || (pkt_whole && (level != '0));
        ready      = ((lvl_x >= thr_x) && (lvl_x >= CMP_W'(4))) || pkt_whole;
    end
endmodule

// File: rtl/rxd_desc_regs.sv
module rxd_desc_regs
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [1:0]        idx,
    input  logic [WORD_W-1:0] rdata,
    output rxd_desc_t         desc
);
    logic [2:0][WORD_W-1:0] words;

    for (genvar g = 0; g < 3; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (ld && (idx == 2'(g)))
                words[g] <= rdata;
        end
    end

    assign desc.link     = words[0];
    assign desc.ctl      = words[1];
    assign desc.buf_addr = words[2];
endmodule

// File: rtl/rxd_status_pack.sv
module rxd_status_pack
    import rxd_pkg::*;
(
    input  logic              more,
    input  logic              ovr,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] word
);
    rxd_stat_t s;
    always_comb begin
        s.more  = more;
        s.ovr   = ovr && !more;
        s.count = count;
        word    = pack_status(s);
    end
endmodule

// File: rtl/rxd_seq_ctrl.sv
module rxd_seq_ctrl
    import rxd_pkg::*;
#(
    parameter  int unsigned ADDR_W    = 32,
    parameter  int unsigned MAX_BURST = 8,
    localparam int unsigned BC_W      = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_value,
    input  logic              ready,
    input  logic              word_avail,
    input  logic [WORD_W-1:0] fifo_rdata,
    input  logic              fifo_last,
    input  logic [2:0]        fifo_last_bytes,
    input  logic              fifo_ovr,
    output logic              fifo_rd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  rxd_desc_t         desc,
    output logic              desc_ld,
    output logic [1:0]        desc_idx,
    input  logic [WORD_W-1:0] stat_word,
    output logic              stat_more,
    output logic              stat_ovr,
    output logic [CNT_W-1:0]  stat_count,
    output logic [ADDR_W-1:0] ptr,
    output rxd_state_e        st,
    output logic [BC_W-1:0]   beats
);
    logic              req_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              used_q;
    logic [CNT_W-1:0]  count;
    logic [2:0]        nb_q;
    logic              last_q;
    logic              ovr_q;
    logic              more_q;
    logic [CNT_W-1:0]  size;
    logic [CNT_W-1:0]  cnt_nx;
    logic              take;
    logic [ADDR_W-1:0] link_a;
    logic [ADDR_W-1:0] buf_a;

    always_comb begin
        size   = desc.ctl[CNT_W-1:0];
        cnt_nx = count + CNT_W'(nb_q);
        link_a = desc.link[ADDR_W-1:0];
        buf_a  = desc.buf_addr[ADDR_W-1:0];
        take   = (st == S_FRAG) && !req_q && word_avail
                 && (beats < BC_W'(MAX_BURST)) && (count < size);
    end

    assign fifo_rd    = take;
    assign mem_req    = req_q;
    assign mem_we     = we_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
    assign desc_ld    = (st == S_DREAD) && req_q && mem_ack;
    assign stat_more  = more_q;
    assign stat_ovr   = ovr_q;
    assign stat_count = count;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            ptr      <= '0;
            used_q   <= 1'b0;
            req_q    <= 1'b0;
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            desc_idx <= '0;
            count    <= '0;
            beats    <= '0;
            nb_q     <= '0;
            last_q   <= 1'b0;
            ovr_q    <= 1'b0;
            more_q   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (ptr_load) begin
                        ptr    <= ptr_value;
                        used_q <= 1'b0;
                    end else if (rx_en) begin
                        req_q    <= 1'b1;
                        we_q     <= 1'b0;
                        addr_q   <= ptr;
                        desc_idx <= '0;
                        st       <= used_q ? S_REFRESH : S_DREAD;
                    end
                end
                S_REFRESH: begin
                    if (mem_ack) begin
                        if (mem_rdata[ADDR_W-1:0] != '0) begin
                            ptr      <= mem_rdata[ADDR_W-1:0];
                            used_q   <= 1'b0;
                            addr_q   <= mem_rdata[ADDR_W-1:0];
                            desc_idx <= '0;
                            st       <= S_DREAD;
                        end else begin
                            req_q <= 1'b0;
                            st    <= S_IDLE;
                        end
                    end
                end
                S_DREAD: begin
                    if (mem_ack) begin
                        if (desc_idx == 2'd2) begin
                            req_q <= 1'b0;
                            count <= '0;
                            beats <= '0;
                            st    <= desc.ctl[OWN_BIT] ? S_IDLE : S_BLOCK;
                        end else begin
                            desc_idx <= desc_idx + 2'd1;
                            addr_q   <= ptr + ADDR_W'({desc_idx + 2'd1, 2'b00});
                        end
                    end
                end
                S_BLOCK: begin
                    beats <= '0;
                    if (ready)
                        st <= S_FRAG;
                end
                S_FRAG: begin
                    if (req_q) begin
                        if (mem_ack) begin
                            req_q <= 1'b0;
                            count <= cnt_nx;
                            beats <= beats + BC_W'(1);
                            if (last_q) begin
                                more_q <= 1'b0;
                                st     <= S_DWRITE;
                            end else if (cnt_nx >= size) begin
                                more_q <= 1'b1;
                                ovr_q  <= 1'b0;
                                st     <= S_DWRITE;
                            end
                        end
                    end else if (take) begin
                        req_q   <= 1'b1;
                        we_q    <= 1'b1;
                        addr_q  <= buf_a + ADDR_W'(count);
                        wdata_q <= fifo_rdata;
                        nb_q    <= fifo_last ? fifo_last_bytes : 3'd4;
                        last_q  <= fifo_last;
                        ovr_q   <= fifo_last && fifo_ovr;
                    end else begin
                        st <= S_BLOCK;
                    end
                end
                S_DWRITE: begin
                    if (!req_q) begin
                        req_q   <= 1'b1;
                        we_q    <= 1'b1;
                        addr_q  <= ptr + ADDR_W'(4);
                        wdata_q <= stat_word;
                    end else if (mem_ack) begin
                        req_q <= 1'b0;
                        st    <= S_ADV;
                    end
                end
                S_ADV: begin
                    if (link_a == '0) begin
                        used_q <= 1'b1;
                        st     <= S_IDLE;
                    end else begin
                        ptr      <= link_a;
                        req_q    <= 1'b1;
                        we_q     <= 1'b0;
                        addr_q   <= link_a;
                        desc_idx <= '0;
                        st       <= S_DREAD;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxd_dma_seq.sv
module rxd_dma_seq
    import rxd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LVL_W     = 12,
    parameter int unsigned TH_W      = 5,
    parameter int unsigned MAX_BURST = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_value,
    input  logic [TH_W-1:0]   drain_th,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              fifo_pkt_whole,
    input  logic [31:0]       fifo_rdata,
    input  logic              fifo_last,
    input  logic [2:0]        fifo_last_bytes,
    input  logic              fifo_ovr,
    output logic              fifo_rd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] desc_ptr,
    output logic              rx_active
);
    localparam int unsigned BC_W = $clog2(MAX_BURST + 1);

    logic              ready;
    logic              word_avail;
    rxd_desc_t         desc;
    logic              desc_ld;
    logic [1:0]        desc_idx;
    logic [WORD_W-1:0] stat_word;
    logic              stat_more;
    logic              stat_ovr;
    logic [CNT_W-1:0]  stat_count;
    rxd_state_e        st;
    logic [BC_W-1:0]   beats;

    rxd_drain_gate #(.LVL_W(LVL_W), .TH_W(TH_W)) u_gate (
        .level      (fifo_level),
        .pkt_whole  (fifo_pkt_whole),
        .th         (drain_th),
        .ready      (ready),
        .word_avail (word_avail)
    );

    rxd_desc_regs u_desc (
        .clk   (clk),
        .rst   (rst),
        .ld    (desc_ld),
        .idx   (desc_idx),
        .rdata (mem_rdata),
        .desc  (desc)
    );

    rxd_status_pack u_stat (
        .more  (stat_more),
        .ovr   (stat_ovr),
        .count (stat_count),
        .word  (stat_word)
    );

    rxd_seq_ctrl #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .rx_en           (rx_en),
        .ptr_load        (ptr_load),
        .ptr_value       (ptr_value),
        .ready           (ready),
        .word_avail      (word_avail),
        .fifo_rdata      (fifo_rdata),
        .fifo_last       (fifo_last),
        .fifo_last_bytes (fifo_last_bytes),
        .fifo_ovr        (fifo_ovr),
        .fifo_rd         (fifo_rd),
        .mem_req         (mem_req),
        .mem_we          (mem_we),
        .mem_addr        (mem_addr),
        .mem_wdata       (mem_wdata),
        .mem_rdata       (mem_rdata),
        .mem_ack         (mem_ack),
        .desc            (desc),
        .desc_ld         (desc_ld),
        .desc_idx        (desc_idx),
        .stat_word       (stat_word),
        .stat_more       (stat_more),
        .stat_ovr        (stat_ovr),
        .stat_count      (stat_count),
        .ptr             (desc_ptr),
        .st              (st),
        .beats           (beats)
    );

    assign rx_active = (st != S_IDLE);
endmodule

// File: rtl/rxd_dma_seq_chk.sv
module rxd_dma_seq_chk
    import rxd_pkg::*;
#(
    parameter  int unsigned ADDR_W    = 32,
    parameter  int unsigned LVL_W     = 12,
    parameter  int unsigned MAX_BURST = 8,
    localparam int unsigned BC_W      = $clog2(MAX_BURST + 1)
) (
    input logic              clk,
    input logic              rst,
    input rxd_state_e        st,
    input logic [BC_W-1:0]   beats,
    input logic              fifo_rd,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [ADDR_W-1:0] desc_ptr,
    input logic              ptr_load,
    input logic [ADDR_W-1:0] ptr_value
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> (!mem_req && !fifo_rd));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    p_pop_has_data_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (fifo_level != '0));

    p_status_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && st == S_DWRITE)
            |-> (mem_addr == desc_ptr + ADDR_W'(4) && mem_wdata[OWN_BIT]));

    p_abort_mirror_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && st == S_DWRITE)
            |-> (mem_wdata[ABRT_BIT] == mem_wdata[OVR_BIT]));

    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && !ptr_load) |=> $stable(desc_ptr));

    p_ptr_load_r10: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && ptr_load) |=> (desc_ptr == $past(ptr_value)));

    p_burst_cap_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (beats < BC_W'(MAX_BURST)));
endmodule

bind rxd_dma_seq rxd_dma_seq_chk #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .MAX_BURST(MAX_BURST)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .st         (st),
    .beats      (beats),
    .fifo_rd    (fifo_rd),
    .fifo_level (fifo_level),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .desc_ptr   (desc_ptr),
    .ptr_load   (ptr_load),
    .ptr_value  (ptr_value)
);

// File: tb/tb_rxd_dma_seq.sv
module tb_rxd_dma_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic        ptr_load = 1'b0;
    logic [31:0] ptr_value = '0;
    logic [4:0]  drain_th = 5'd2;
    logic [11:0] fifo_level = '0;
    logic        fifo_pkt_whole = 1'b0;
    logic [31:0] fifo_rdata = '0;
    logic        fifo_last = 1'b0;
    logic [2:0]  fifo_last_bytes = 3'd4;
    logic        fifo_ovr = 1'b0;
    logic        fifo_rd;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [31:0] desc_ptr;
    logic        rx_active;

    always #2.5 clk = ~clk;

    rxd_dma_seq dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .ptr_load(ptr_load),
        .ptr_value(ptr_value), .drain_th(drain_th), .fifo_level(fifo_level),
        .fifo_pkt_whole(fifo_pkt_whole), .fifo_rdata(fifo_rdata),
        .fifo_last(fifo_last), .fifo_last_bytes(fifo_last_bytes),
        .fifo_ovr(fifo_ovr), .fifo_rd(fifo_rd), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .desc_ptr(desc_ptr),
        .rx_active(rx_active)
    );

    // host memory model with a host write port
    logic [31:0] mem [0:1023];
    logic        hw_en = 1'b0;
    logic [31:0] hw_addr = '0, hw_data = '0;
    always @(posedge clk) begin
        if (hw_en) mem[hw_addr[11:2]] <= hw_data;
        if (rst) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end else mem_ack <= 1'b0;
    end

    // FIFO model: words pushed by the stimulus, popped on fifo_rd
    logic [31:0] fw_data [0:255];
    logic        fw_last [0:255];
    logic [2:0]  fw_lb   [0:255];
    logic        fw_ovr  [0:255];
    int tail = 0;
    int head = 0;
    always @(posedge clk) if (fifo_rd) head <= head + 1;
    always @(negedge clk) begin
        int   lvl;
        logic whole;
        lvl = 0; whole = 1'b0;
        for (int i = 0; i < 256; i++)
            if (i >= head && i < tail) begin
                lvl += fw_last[i] ? int'(fw_lb[i]) : 4;
                if (fw_last[i]) whole = 1'b1;
            end
        fifo_level     = 12'(lvl);
        fifo_pkt_whole = whole;
        if (head < tail) begin
            fifo_rdata = fw_data[head]; fifo_last = fw_last[head];
            fifo_last_bytes = fw_lb[head]; fifo_ovr = fw_ovr[head];
        end else begin
            fifo_rdata = '0; fifo_last = 1'b0; fifo_last_bytes = 3'd4; fifo_ovr = 1'b0;
        end
    end

    // scoreboard of expected memory writes
    logic [31:0] exp_addr [0:127];
    logic [31:0] exp_data [0:127];
    string       exp_tag  [0:127];
    int exp_wr = 0;
    int exp_rd = 0;
    int mon_chk = 0, mon_fail = 0, wr_cnt = 0;
    logic [31:0] rd_log [0:63];
    int rd_cnt = 0;

    always @(negedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            if (mem_we) begin
                wr_cnt++;
                mon_chk++;
                if (exp_rd >= exp_wr) begin
                    mon_fail++;
                    $display("FAIL R5: unexpected write actual %h@%h expected none", mem_wdata, mem_addr);
                end else begin
                    if (mem_addr !== exp_addr[exp_rd] || mem_wdata !== exp_data[exp_rd]) begin
                        mon_fail++;
                        $display("FAIL %s: actual %h@%h expected %h@%h", exp_tag[exp_rd],
                                 mem_wdata, mem_addr, exp_data[exp_rd], exp_addr[exp_rd]);
                    end
                    exp_rd++;
                end
            end else begin
                if (rd_cnt < 64) rd_log[rd_cnt] = mem_addr;
                rd_cnt++;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1 hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(posedge clk); #1 hw_en = 1'b0;
    endtask

    task automatic mk_desc(input logic [31:0] a, input logic [31:0] link,
                           input logic [31:0] ctl, input logic [31:0] bufa);
        host_wr(a, link); host_wr(a + 4, ctl); host_wr(a + 8, bufa);
    endtask

    task automatic pulse_en();
        @(posedge clk); #1 rx_en = 1'b1;
        @(posedge clk); #1 rx_en = 1'b0;
    endtask

    task automatic load_ptr(input logic [31:0] v);
        @(posedge clk); #1 ptr_load = 1'b1; ptr_value = v;
        @(posedge clk); #1 ptr_load = 1'b0;
    endtask

    // push words [from,to) of a packet of n bytes
    task automatic push_pkt(input logic [31:0] seed, input int n, input bit ovr,
                            input int from, input int to);
        int nw;
        nw = (n + 3) / 4;
        @(posedge clk); #1;
        for (int w = from; w < to; w++) begin
            fw_data[tail] = seed + 32'(w);
            fw_last[tail] = (w == nw - 1);
            fw_lb[tail]   = (w == nw - 1) ? 3'(n - 4 * (nw - 1)) : 3'd4;
            fw_ovr[tail]  = ovr && (w == nw - 1);
            tail++;
        end
    endtask

    // descriptor plan for the next expected packet
    logic [31:0] pl_daddr [0:3];
    logic [31:0] pl_buf   [0:3];
    int          pl_size  [0:3];

    task automatic exp_push(input logic [31:0] a, input logic [31:0] d, input string t);
        exp_addr[exp_wr] = a; exp_data[exp_wr] = d; exp_tag[exp_wr] = t; exp_wr++;
    endtask

    task automatic expect_pkt(input int n, input logic [31:0] seed, input bit ovr, input int nd);
        int nw, w, left;
        nw = (n + 3) / 4; w = 0; left = n;
        for (int k = 0; k < nd && w < nw; k++) begin
            int  here;
            bit  fin;
            logic [31:0] st;
            here = 0;
            for (int j = 0; j < pl_size[k] / 4 && w < nw; j++) begin
                exp_push(pl_buf[k] + 32'(4 * j), seed + 32'(w), "R5");
                w++;
            end
            fin = (w == nw);
            here = fin ? left : pl_size[k];
            left -= here;
            st = 32'h8000_0000 | 32'(here);
            if (!fin) st |= 32'h4000_0000;
            else if (ovr) st |= 32'h0600_0000;
            else st |= 32'h0800_0000;
            exp_push(pl_daddr[k] + 4, st, fin ? (ovr ? "R8" : "R7") : "R6");
        end
    endtask

    task automatic wait_sb(input string req);
        int t;
        t = 0;
        while (exp_rd != exp_wr && t < 2000) begin @(negedge clk); t++; end
        repeat (12) @(negedge clk);
        chk(exp_rd == exp_wr, req, 32'(exp_rd), 32'(exp_wr));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk + mon_chk - n_fail - mon_fail,
                     n_chk + mon_chk + 1);
            $finish;
        end
    end

    initial begin
        int base, wbase, hbase;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(rx_active == 1'b0, "R1", 32'(rx_active), 0);
        chk(mem_req == 1'b0 && fifo_rd == 1'b0, "R1", {mem_req, fifo_rd}, 0);
        chk(desc_ptr == 32'h0, "R1", desc_ptr, 0);

        mk_desc(32'h100, 32'h110, 32'h0000_0040, 32'h400);
        mk_desc(32'h110, 32'h120, 32'h0000_0010, 32'h480);
        mk_desc(32'h120, 32'h130, 32'h0000_0010, 32'h500);
        mk_desc(32'h130, 32'h140, 32'h0000_0040, 32'h580);
        mk_desc(32'h140, 32'h000, 32'h8000_0040, 32'h600);

        // single short packet with a partial last word
        load_ptr(32'h100);
        base = rd_cnt;
        pl_daddr[0] = 32'h100; pl_buf[0] = 32'h400; pl_size[0] = 64;
        expect_pkt(10, 32'hA000_0000, 1'b0, 1);
        pulse_en();
        push_pkt(32'hA000_0000, 10, 1'b0, 0, 3);
        wait_sb("R7");
        chk(rd_log[base] == 32'h100, "R2", rd_log[base], 32'h100);
        chk(rd_log[base + 1] == 32'h104, "R2", rd_log[base + 1], 32'h104);
        chk(rd_log[base + 2] == 32'h108, "R2", rd_log[base + 2], 32'h108);
        chk(desc_ptr == 32'h110, "R2", desc_ptr, 32'h110);

        // 40-byte packet across two 16-byte buffers and a third; next owned
        pl_daddr[0] = 32'h110; pl_buf[0] = 32'h480; pl_size[0] = 16;
        pl_daddr[1] = 32'h120; pl_buf[1] = 32'h500; pl_size[1] = 16;
        pl_daddr[2] = 32'h130; pl_buf[2] = 32'h580; pl_size[2] = 64;
        expect_pkt(40, 32'hB000_0000, 1'b0, 3);
        push_pkt(32'hB000_0000, 40, 1'b0, 0, 10);
        wait_sb("R6");
        chk(rx_active == 1'b0, "R3", 32'(rx_active), 0);
        chk(desc_ptr == 32'h140, "R3", desc_ptr, 32'h140);

        // overrun packet into a descriptor with a null link
        mk_desc(32'h140, 32'h000, 32'h0000_0040, 32'h600);
        pl_daddr[0] = 32'h140; pl_buf[0] = 32'h600; pl_size[0] = 64;
        expect_pkt(8, 32'hC000_0000, 1'b1, 1);
        pulse_en();
        push_pkt(32'hC000_0000, 8, 1'b1, 0, 2);
        wait_sb("R8");
        chk(rx_active == 1'b0, "R9", 32'(rx_active), 0);
        chk(desc_ptr == 32'h140, "R9", desc_ptr, 32'h140);

        // patch the link, enable again: the link is re-read first
        mk_desc(32'h150, 32'h160, 32'h0000_0040, 32'h680);
        mk_desc(32'h160, 32'h000, 32'h0000_0040, 32'h700);
        host_wr(32'h140, 32'h150);
        base = rd_cnt;
        pulse_en();
        repeat (30) @(negedge clk);
        chk(rd_log[base] == 32'h140, "R9", rd_log[base], 32'h140);
        chk(rd_log[base + 1] == 32'h150, "R9", rd_log[base + 1], 32'h150);
        chk(desc_ptr == 32'h150, "R9", desc_ptr, 32'h150);
        chk(rx_active == 1'b1, "R9", 32'(rx_active), 1);

        // staged packet against a 32-byte threshold
        @(posedge clk); #1 drain_th = 5'd4;
        pl_daddr[0] = 32'h150; pl_buf[0] = 32'h680; pl_size[0] = 64;
        expect_pkt(36, 32'hD000_0000, 1'b0, 1);
        wbase = wr_cnt; hbase = head;
        push_pkt(32'hD000_0000, 36, 1'b0, 0, 4);
        repeat (40) @(negedge clk);
        chk(wr_cnt == wbase, "R4", 32'(wr_cnt - wbase), 0);
        chk(head == hbase, "R4", 32'(head - hbase), 0);
        push_pkt(32'hD000_0000, 36, 1'b0, 4, 8);
        repeat (60) @(negedge clk);
        chk(wr_cnt - wbase == 8, "R4", 32'(wr_cnt - wbase), 8);
        push_pkt(32'hD000_0000, 36, 1'b0, 8, 9);
        wait_sb("R7");

        // whole packet below a high threshold still drains
        @(posedge clk); #1 drain_th = 5'd31;
        pl_daddr[0] = 32'h160; pl_buf[0] = 32'h700; pl_size[0] = 64;
        expect_pkt(12, 32'hE000_0000, 1'b0, 1);
        push_pkt(32'hE000_0000, 12, 1'b0, 0, 3);
        wait_sb("R4");
        chk(rx_active == 1'b0, "R9", 32'(rx_active), 0);
        chk(desc_ptr == 32'h160, "R9", desc_ptr, 32'h160);

        // pointer load cancels the re-read; first descriptor is now owned
        load_ptr(32'h100);
        @(negedge clk);
        chk(desc_ptr == 32'h100, "R10", desc_ptr, 32'h100);
        base = rd_cnt;
        wbase = wr_cnt;
        pulse_en();
        repeat (30) @(negedge clk);
        chk(rd_cnt - base == 3, "R10", 32'(rd_cnt - base), 3);
        chk(rd_log[base] == 32'h100, "R10", rd_log[base], 32'h100);
        chk(rx_active == 1'b0, "R3", 32'(rx_active), 0);
        chk(wr_cnt == wbase, "R3", 32'(wr_cnt - wbase), 0);
        chk(desc_ptr == 32'h100, "R3", desc_ptr, 32'h100);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk + mon_chk - n_fail - mon_fail, n_chk + mon_chk);
        $finish;
    end
endmodule